// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock waveform of an I2C master from a fast peripheral clock. A programmable divider sets the time base. A 2-bit ratio select picks one of a few low/high weightings, so the clock can be stretched asymmetrically: the low phase is long enough for data setup and the high phase is short. The block drives the line only through an open-drain enable (`scl_oe` high means pull SCL low, low means release).

Two single-cycle strobes mark the first cycle of each low phase and of each high phase, and a bit engine sequences data and conditions on these. The high phase is timed only while the sensed SCL line is actually high. A slave that holds SCL low therefore lengthens the high phase by exactly the time it holds the line. Divider and ratio settings are sampled once per period, at the moment a new low phase begins, so software can change them at any time without producing a runt pulse.

Top module: `scl_clkgen`

## Requirements
- R1: With ratio select 0 and divider D, each low phase lasts 4*(D+1)+2 clocks and each high phase 4*(D+1)+2 clocks.
- R2: With ratio select 1, the low phase lasts 6*(D+1)+2 clocks and the high phase 3*(D+1)+2 clocks.
- R3: With ratio select 2, the low phase lasts 11*(D+1)+2 clocks and the high phase 3*(D+1)+2 clocks.
- R4: Ratio select 3 gives the same timing as ratio select 0 (4 low, 4 high).
- R5: With the line not held by a slave, one full period (low_stb to the next low_stb) lasts (Nlow+Nhigh)*(D+1)+4 clocks; no low phase is shorter than 6 clocks.
- R6: When `slave_mode` is 1, a divider value of 0 is treated as 1; nonzero dividers are used unchanged.
- R7: During the high phase the count advances only in cycles where `scl_sense` is 1, so each cycle the line is held low by another device adds one clock to the high phase while `scl_oe` stays 0.
- R8: Changes to `ratio_sel`, `div_val` or `slave_mode` take effect only from the next low phase; the period in progress keeps its timing.
- R9: While `en` is 0, `scl_oe`, `low_stb` and `high_stb` are 0 from the next clock on and all counting restarts; after re-enabling, the first low phase has full length.
- R10: `low_stb` is 1 for exactly the first cycle in which `scl_oe` is 1, `high_stb` for exactly the first cycle of release after a low phase; they are never 1 together.
- R11: With `en` 1 and `run` 0 the line stays released; if `run` falls during a period, that period completes and the line then stays released.
- R12: During and right after synchronous reset `scl_oe`, `low_stb` and `high_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 releases the line and clears counters |
| run | input | 1 | Request to keep generating clock periods |
| slave_mode | input | 1 | 1 forces a minimum divider of 1 |
| ratio_sel | input | 2 | Low/high ratio select (0: 4/4, 1: 6/3, 2: 11/3, 3: 4/4) |
| div_val | input | DIV_W | Divider value D; time unit is D+1 clocks |
| scl_sense | input | 1 | Sensed SCL level (1 = line high) |
| scl_oe | output | 1 | Open-drain enable, 1 pulls SCL low |
| high_stb | output | 1 | Pulse on first cycle of a high phase |
| low_stb | output | 1 | Pulse on first cycle of a low phase |

## Verification
The bench measures every ratio select, including the undefined code 3, at several divider values. An off-by-one in the +2 phase padding would show as periods one or two clocks off the formula, and a missing fallback for code 3 would leave the line low or high for the wrong width. It changes the settings halfway through a low phase: a design that samples them continuously would bend the current period instead of the next one. Clock stretching by a simulated slave must lengthen the high phase by exactly the held cycles, where a free-running counter would cut the high time short. Disabling mid-phase, dropping `run` mid-period and a zero divider in slave mode are each checked, since a wrong design would leave the line driven, stop in the low phase or produce a 6-clock phase instead of 10.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_t;

  // Width of the per-phase weight (largest weight is 11)
  localparam int unsigned WEIGHT_W = 4;

  typedef struct packed {
    logic [WEIGHT_W-1:0] n_low;
    logic [WEIGHT_W-1:0] n_high;
  } scl_weight_t;

endpackage

// File: rtl/scl_ratio_lut.sv
module scl_ratio_lut
  import scl_gen_pkg::*;
(
  input  logic [1:0]  sel,
  output scl_weight_t weight
);

  always_comb begin
    unique case (sel)
      2'd1:    weight = '{n_low: 4'd6,  n_high: 4'd3};
      2'd2:    weight = '{n_low: 4'd11, n_high: 4'd3};
      default: weight = '{n_low: 4'd4,  n_high: 4'd4};  // codes 0 and 3
    endcase
  end

endmodule

// File: rtl/scl_cfg_capture.sv
module scl_cfg_capture
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = DIV_W + 6
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             slave_mode,
  input  logic [1:0]       ratio_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic [LEN_W-1:0] len_low,
  output logic [LEN_W-1:0] len_high
);

  localparam int unsigned UNIT_W = DIV_W + 1;

  scl_weight_t      weight;
  logic [UNIT_W-1:0] unit;
  logic [LEN_W-1:0]  next_low;
  logic [LEN_W-1:0]  next_high;

  scl_ratio_lut u_lut (
    .sel    (ratio_sel),
    .weight (weight)
  );

  // Time unit in clocks: effective divider plus one
  always_comb begin
    if (slave_mode && (div_val == '0))
      unit = UNIT_W'(2);
    else
      unit = UNIT_W'(div_val) + UNIT_W'(1);
  end

  always_comb begin
    next_low  = LEN_W'(LEN_W'(weight.n_low)  * LEN_W'(unit)) + LEN_W'(2);
    next_high = LEN_W'(LEN_W'(weight.n_high) * LEN_W'(unit)) + LEN_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_low  <= '0;
      len_high <= '0;
    end else if (load) begin
      len_low  <= next_low;
      len_high <= next_high;
    end
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int unsigned LEN_W = 14
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             scl_sense,
  input  logic [LEN_W-1:0] len_low,
  input  logic [LEN_W-1:0] len_high,
  output logic             load_cfg,
  output logic             scl_oe,
  output logic             high_stb,
  output logic             low_stb
);

  scl_phase_t       phase;
  logic [LEN_W-1:0] cnt;
  logic             low_last;
  logic             high_last;

  assign low_last  = (cnt == len_low  - LEN_W'(1));
  assign high_last = (cnt == len_high - LEN_W'(1));

  // Settings are sampled exactly when a new low phase is entered
  always_comb begin
    load_cfg = 1'b0;
    if (en && run) begin
      if (phase == PH_IDLE)
        load_cfg = 1'b1;
      else if ((phase == PH_HIGH) && scl_sense && high_last)
        load_cfg = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      scl_oe   <= 1'b0;
      high_stb <= 1'b0;
      low_stb  <= 1'b0;
    end else begin
      high_stb <= 1'b0;
      low_stb  <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (run) begin
            phase   <= PH_LOW;
            scl_oe  <= 1'b1;
            low_stb <= 1'b1;
          end
        end
        PH_LOW: begin
          if (low_last) begin
            phase    <= PH_HIGH;
            cnt      <= '0;
            scl_oe   <= 1'b0;
            high_stb <= 1'b1;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_sense) begin
            if (high_last) begin
              cnt <= '0;
              if (run) begin
                phase   <= PH_LOW;
                scl_oe  <= 1'b1;
                low_stb <= 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
        end
        default: begin
          phase  <= PH_IDLE;
          cnt    <= '0;
          scl_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             slave_mode,
  input  logic [1:0]       ratio_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             scl_sense,
  output logic             scl_oe,
  output logic             high_stb,
  output logic             low_stb
);

  localparam int unsigned LEN_W = DIV_W + 6;

  logic             load_cfg;
  logic [LEN_W-1:0] len_low;
  logic [LEN_W-1:0] len_high;

  scl_cfg_capture #(
    .DIV_W (DIV_W),
    .LEN_W (LEN_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load       (load_cfg),
    .slave_mode (slave_mode),
    .ratio_sel  (ratio_sel),
    .div_val    (div_val),
    .len_low    (len_low),
    .len_high   (len_high)
  );

  scl_phase_seq #(
    .LEN_W (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .run       (run),
    .scl_sense (scl_sense),
    .len_low   (len_low),
    .len_high  (len_high),
    .load_cfg  (load_cfg),
    .scl_oe    (scl_oe),
    .high_stb  (high_stb),
    .low_stb   (low_stb)
  );

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_oe,
  input logic high_stb,
  input logic low_stb
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)
      low_run <= '0;
    else if (scl_oe)
      low_run <= (low_run == 16'hFFFF) ? low_run : low_run + 16'd1;
    else
      low_run <= '0;
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(low_stb && high_stb));

  // R10
  low_stb_edge_chk: assert property (@(posedge clk) disable iff (rst)
    low_stb |-> (scl_oe && !$past(scl_oe)));

  // R10
  high_stb_edge_chk: assert property (@(posedge clk) disable iff (rst)
    high_stb |-> (!scl_oe && $past(scl_oe)));

  // R9
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !low_stb && !high_stb));

  // R5
  low_min_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && $past(en)) |-> (high_stb && (low_run >= 16'd6)));

endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .scl_oe   (scl_oe),
  .high_stb (high_stb),
  .low_stb  (low_stb)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             run = 1'b0;
  logic             slave_mode = 1'b0;
  logic [1:0]       ratio_sel = 2'd0;
  logic [DIV_W-1:0] div_val = '0;
  logic             stretch = 1'b0;
  logic             scl_sense;
  logic             scl_oe, high_stb, low_stb;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus model: line is high only when nobody pulls it low
  assign scl_sense = !scl_oe && !stretch;

  scl_clkgen #(.DIV_W(DIV_W)) u_scl_clkgen (
    .clk(clk), .rst(rst), .en(en), .run(run), .slave_mode(slave_mode),
    .ratio_sel(ratio_sel), .div_val(div_val), .scl_sense(scl_sense),
    .scl_oe(scl_oe), .high_stb(high_stb), .low_stb(low_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int w_low(input int sel);
    return (sel == 1) ? 6 : (sel == 2) ? 11 : 4;
  endfunction
  function automatic int w_high(input int sel);
    return (sel == 1 || sel == 2) ? 3 : 4;
  endfunction
  function automatic int unit_of(input int d, input bit slv);
    return (slv && d == 0) ? 2 : d + 1;
  endfunction

  task automatic wait_low_stb();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!low_stb && guard < 5000);
  endtask

  // Called at a negedge where low_stb is 1; returns at the next such negedge
  task automatic measure(output int lo, output int hi, output bit hs_ok);
    int guard = 0;
    lo = 0; hi = 0;
    while (scl_oe && guard < 5000) begin
      lo++; guard++;
      @(negedge clk);
    end
    hs_ok = high_stb;
    while (!low_stb && guard < 5000) begin
      hi++; guard++;
      @(negedge clk);
    end
  endtask

  task automatic t_ratio(input int sel, input int d, input bit slv, input string req);
    int lo, hi, el, eh;
    bit hs;
    @(negedge clk);
    ratio_sel = 2'(sel); div_val = DIV_W'(d); slave_mode = slv;
    wait_low_stb();
    measure(lo, hi, hs);
    el = w_low(sel) * unit_of(d, slv) + 2;
    eh = w_high(sel) * unit_of(d, slv) + 2;
    check(lo == el, {req, " low"}, lo, el);
    check(hi == eh, {req, " high"}, hi, eh);
    check(lo + hi == (w_low(sel) + w_high(sel)) * unit_of(d, slv) + 4, "R5 period", lo + hi,
          (w_low(sel) + w_high(sel)) * unit_of(d, slv) + 4);
    check(hs, "R10 high_stb at release", hs, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; run = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_oe && !low_stb && !high_stb, "R12 in reset", {scl_oe, low_stb, high_stb}, 0);
    en = 1'b0; run = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!scl_oe && !low_stb && !high_stb, "R12 after reset", {scl_oe, low_stb, high_stb}, 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    en = 1'b1; run = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (scl_oe || low_stb) seen++;
    end
    check(seen == 0, "R11 idle released", seen, 0);
    run = 1'b1;
  endtask

  task automatic t_stretch();
    int n, lo, hi;
    bit hs;
    int guard = 0;
    @(negedge clk);
    ratio_sel = 2'd1; div_val = 8'd1; slave_mode = 1'b0;
    wait_low_stb();
    wait_low_stb();
    do @(negedge clk); while (!high_stb);
    stretch = 1'b1;
    n = 1;
    repeat (5) begin
      @(negedge clk);
      n++;
      check(!scl_oe, "R7 held released while stretched", scl_oe, 0);
    end
    stretch = 1'b0;
    forever begin
      @(negedge clk);
      guard++;
      if (low_stb || guard > 5000) break;
      n++;
    end
    check(n == 3 * 2 + 2 + 5, "R7 stretched high", n, 3 * 2 + 2 + 5);
    measure(lo, hi, hs);
    check(hi == 8, "R7 next high unstretched", hi, 8);
  endtask

  task automatic t_change();
    int lo, hi, lo2, hi2;
    bit hs;
    @(negedge clk);
    ratio_sel = 2'd0; div_val = 8'd1; slave_mode = 1'b0;
    wait_low_stb();
    wait_low_stb();
    repeat (3) @(negedge clk);
    ratio_sel = 2'd2; div_val = 8'd0;
    // Finish the current period by hand: 3 low cycles already seen
    lo = 3; hi = 0;
    while (scl_oe) begin lo++; @(negedge clk); end
    while (!low_stb) begin hi++; @(negedge clk); end
    check(lo == 10, "R8 current low unchanged", lo, 10);
    check(hi == 10, "R8 current high unchanged", hi, 10);
    measure(lo2, hi2, hs);
    check(lo2 == 13, "R8 new low applied", lo2, 13);
    check(hi2 == 5, "R8 new high applied", hi2, 5);
  endtask

  task automatic t_disable();
    int lo, hi, seen;
    bit hs;
    @(negedge clk);
    ratio_sel = 2'd0; div_val = 8'd2;
    wait_low_stb();
    wait_low_stb();
    repeat (4) @(negedge clk);
    en = 1'b0;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (scl_oe || low_stb || high_stb) seen++;
    end
    check(seen == 0, "R9 released when disabled", seen, 0);
    en = 1'b1;
    @(negedge clk);
    check(low_stb && scl_oe, "R9 restart low", {low_stb, scl_oe}, 3);
    measure(lo, hi, hs);
    check(lo == 14, "R9 full low after enable", lo, 14);
  endtask

  task automatic t_run_drop();
    int lo, hs_cnt, late;
    @(negedge clk);
    ratio_sel = 2'd2; div_val = 8'd1;
    wait_low_stb();
    wait_low_stb();
    run = 1'b0;
    lo = 0;
    while (scl_oe) begin lo++; @(negedge clk); end
    check(lo == 24, "R11 period completes", lo, 24);
    hs_cnt = 0; late = 0;
    repeat (60) begin
      if (high_stb) hs_cnt++;
      if (scl_oe || low_stb) late++;
      @(negedge clk);
    end
    check(hs_cnt == 1, "R11 one high strobe", hs_cnt, 1);
    check(late == 0, "R11 stays released", late, 0);
    run = 1'b1;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_ratio(0, 2, 1'b0, "R1 sel0 div2");
    t_ratio(0, 0, 1'b0, "R1 sel0 div0");
    t_ratio(1, 3, 1'b0, "R2 sel1 div3");
    t_ratio(2, 1, 1'b0, "R3 sel2 div1");
    t_ratio(3, 2, 1'b0, "R4 sel3 div2");
    t_ratio(0, 0, 1'b1, "R6 slave div0");
    t_ratio(1, 3, 1'b1, "R6 slave div3");
    t_stretch();
    t_change();
    t_disable();
    t_run_drop();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule